// File: doc/BRIEF.md
# Serial Port Register and FIFO Controller

This block is the register front end of a master-only synchronous serial port. Software reaches it through a word-addressed bus. It can set a data size, enable the port, turn on an internal loopback and program an interrupt mask. It pushes transmit words into an eight-entry queue and pops received words from a second eight-entry queue. Status, raw interrupt and masked interrupt registers report the queue levels, and a read-only identification window returns fixed bytes.

A word engine moves data between the queues. While the port is enabled, it takes the oldest transmit word and exchanges it for a received word. The exchange goes either over an external valid/ready word port or, in loopback, straight back into the receive queue. The engine stops whenever the receive queue is full, so received data is never lost. A level interrupt is raised from half-depth watermarks on both queues.

Top module: `sport_regfifo`

## Requirements
- R1: After reset, status reads 0x03, raw interrupt status reads 0x08, masked status reads 0x00 and `irq` is low.
- R2: The data size is the low 4 bits of control 0 (offset 0x00). Words pushed by a data write and words stored into the receive queue keep only bits 0..size.
- R3: A data write (offset 0x08) while the transmit queue holds 8 words is discarded, and the held words are unchanged.
- R4: The engine never stores into a full receive queue. Words left in the transmit queue wait, and all words come out of the data register in write order.
- R5: Status (offset 0x0C) reports: bit0 transmit empty, bit1 transmit not full, bit2 receive not empty, bit3 receive full, bit4 busy (an exchange is pending or a word is moving).
- R6: Raw interrupt status (offset 0x18) has bit3 set when the transmit count is at most 4 and bit2 set when the receive count is at least 4. Bits 1 and 0 read zero.
- R7: The interrupt mask (offset 0x14, 4 bits) reads back. Masked status (offset 0x1C) equals mask AND raw, and `irq` is high exactly when that value is nonzero.
- R8: With control 1 bit1 set and bit0 clear, the oldest transmit word is presented on `xchg_tx` with `xchg_valid` held until `xchg_ready`. The returned `xchg_rx` is then stored into the receive queue.
- R9: With control 1 bit1 (enable) clear, no words move and `xchg_valid` stays low.
- R10: A data read with the receive queue empty returns 0 and leaves status unchanged.
- R11: Offsets 0xFE0..0xFFC read, one per word, the bytes 0x22, 0x10, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R12: Control 0 reads back 16 bits, control 1 (offset 0x04) reads back 4 bits, and the prescaler (offset 0x10) reads back its low 8 bits.
- R13: With control 1 bits 1 and 0 both set, transmit words enter the receive queue unchanged, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset, word aligned |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (combinational, valid in the access cycle) |
| xchg_valid | output | 1 | Exchange request |
| xchg_ready | input | 1 | Exchange accepted; `xchg_rx` is valid |
| xchg_tx | output | 16 | Word being transmitted |
| xchg_rx | input | 16 | Word received in exchange |
| irq | output | 1 | Level interrupt |

## Verification
The hardest state to reach is a receive queue that is completely full while the transmit queue still holds words. Loopback moves words faster than the bus refills them, so both queues would drain before reaching that state. To get there, the bench fills the transmit queue beyond eight words with loopback on and reads nothing, which parks the surplus behind a full receive queue. It then drains the data register and checks that every word arrives in order. A stalled external exchange is reached by keeping `xchg_ready` low while words wait, which shows the request held steady and the busy bit set.

// File: rtl/sport_pkg.sv
package sport_pkg;
    // word indices (byte offset >> 2)
    localparam int W_CTRL0  = 0;
    localparam int W_CTRL1  = 1;
    localparam int W_DATA   = 2;
    localparam int W_STAT   = 3;
    localparam int W_PRESC  = 4;
    localparam int W_IMASK  = 5;
    localparam int W_RAW    = 6;
    localparam int W_MASKED = 7;
    localparam int W_IDBASE = 'h3F8;

    // control 1 bit positions
    localparam int C1_LOOP = 0;
    localparam int C1_EN   = 1;

    typedef struct packed {
        logic [15:0] ctrl0;
        logic [3:0]  ctrl1;
        logic [7:0]  presc;
        logic [3:0]  imask;
    } regs_t;

    function automatic logic [7:0] id_byte(input logic [2:0] idx);
        case (idx)
            3'd0:    return 8'h22;
            3'd1:    return 8'h10;
            3'd2:    return 8'h04;
            3'd3:    return 8'h00;
            3'd4:    return 8'h0D;
            3'd5:    return 8'hF0;
            3'd6:    return 8'h05;
            default: return 8'hB1;
        endcase
    endfunction
endpackage

// File: rtl/sport_fifo.sv
module sport_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [W-1:0]     push_data,
    input  logic             pop,
    output logic [W-1:0]     oldest,
    output logic [CNT_W-1:0] count
);
    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PTR_W-1:0]        head;
        logic [CNT_W-1:0]        cnt;
    } fifo_t;

    fifo_t st_d, st_q;
    logic [PTR_W-1:0] rd_idx;

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.mem[st_q.head] = push_data;
            st_d.head = st_q.head + 1'b1;
        end
        st_d.cnt = st_q.cnt + CNT_W'(push) - CNT_W'(pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_idx = st_q.head - st_q.cnt[PTR_W-1:0];
    assign oldest = st_q.mem[rd_idx];
    assign count  = st_q.cnt;
endmodule

// File: rtl/sport_engine.sv
module sport_engine #(
    parameter int W     = 16,
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             port_en,
    input  logic             loopback,
    input  logic [CNT_W-1:0] tx_cnt,
    input  logic [CNT_W-1:0] rx_cnt,
    input  logic [W-1:0]     tx_word,
    input  logic             xchg_ready,
    input  logic [W-1:0]     xchg_rx,
    output logic             xchg_valid,
    output logic [W-1:0]     xchg_tx,
    output logic             tx_pop,
    output logic             rx_push,
    output logic [W-1:0]     rx_word,
    output logic             busy
);
    typedef struct packed {
        logic pending;
    } eng_t;

    eng_t st_d, st_q;
    logic go;

    assign go = port_en && (tx_cnt != '0) && (rx_cnt < CNT_W'(DEPTH));

    always_comb begin
        st_d    = st_q;
        tx_pop  = 1'b0;
        rx_push = 1'b0;
        rx_word = xchg_rx;
        if (st_q.pending) begin
            if (xchg_ready) begin
                tx_pop       = 1'b1;
                rx_push      = 1'b1;
                st_d.pending = 1'b0;
            end
        end else if (go) begin
            if (loopback) begin
                tx_pop  = 1'b1;
                rx_push = 1'b1;
                rx_word = tx_word;
            end else begin
                st_d.pending = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign xchg_valid = st_q.pending;
    assign xchg_tx    = tx_word;
    assign busy       = st_q.pending || go;
endmodule

// File: rtl/sport_regfifo.sv
module sport_regfifo #(
    parameter int DATA_W     = 16,
    parameter int ADDR_W     = 12,
    parameter int FIFO_DEPTH = 8,
    localparam int CNT_W = $clog2(FIFO_DEPTH + 1),
    localparam int WA_W  = ADDR_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              xchg_valid,
    input  logic              xchg_ready,
    output logic [DATA_W-1:0] xchg_tx,
    input  logic [DATA_W-1:0] xchg_rx,
    output logic              irq
);
    import sport_pkg::*;

    localparam logic [WA_W-1:0] A_CTRL0  = WA_W'(W_CTRL0);
    localparam logic [WA_W-1:0] A_CTRL1  = WA_W'(W_CTRL1);
    localparam logic [WA_W-1:0] A_DATA   = WA_W'(W_DATA);
    localparam logic [WA_W-1:0] A_STAT   = WA_W'(W_STAT);
    localparam logic [WA_W-1:0] A_PRESC  = WA_W'(W_PRESC);
    localparam logic [WA_W-1:0] A_IMASK  = WA_W'(W_IMASK);
    localparam logic [WA_W-1:0] A_RAW    = WA_W'(W_RAW);
    localparam logic [WA_W-1:0] A_MASKED = WA_W'(W_MASKED);
    localparam logic [WA_W-1:0] A_IDBASE = WA_W'(W_IDBASE);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FIFO_DEPTH);
    localparam logic [CNT_W-1:0] HALF_CNT = CNT_W'(FIFO_DEPTH / 2);

    regs_t regs_d, regs_q;

    logic [WA_W-1:0]   waddr;
    logic              aligned, wr_acc, rd_acc;
    logic [DATA_W-1:0] size_mask;
    logic              port_en, loopback;
    logic              tx_push, rx_pop;
    logic [CNT_W-1:0]  tx_cnt, rx_cnt;
    logic [DATA_W-1:0] tx_oldest, rx_oldest, eng_rx_word;
    logic              eng_tx_pop, eng_rx_push, busy;
    logic [4:0]        stat;
    logic [3:0]        raw, masked;

    assign waddr   = bus_addr[ADDR_W-1:2];
    assign aligned = (bus_addr[1:0] == 2'b00);
    assign wr_acc  = bus_sel && bus_wr && aligned;
    assign rd_acc  = bus_sel && !bus_wr && aligned;

    // size field selects how many low bits survive
    always_comb begin
        for (int i = 0; i < DATA_W; i++) begin
            size_mask[i] = (i <= int'(regs_q.ctrl0[3:0]));
        end
    end

    assign port_en  = regs_q.ctrl1[C1_EN];
    assign loopback = regs_q.ctrl1[C1_LOOP];
    assign tx_push  = wr_acc && (waddr == A_DATA) && (tx_cnt != FULL_CNT);
    assign rx_pop   = rd_acc && (waddr == A_DATA) && (rx_cnt != '0);

    always_comb begin
        regs_d = regs_q;
        if (wr_acc) begin
            case (waddr)
                A_CTRL0: regs_d.ctrl0 = bus_wdata[15:0];
                A_CTRL1: regs_d.ctrl1 = bus_wdata[3:0];
                A_PRESC: regs_d.presc = bus_wdata[7:0];
                A_IMASK: regs_d.imask = bus_wdata[3:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    sport_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n),
        .push(tx_push), .push_data(bus_wdata & size_mask),
        .pop(eng_tx_pop), .oldest(tx_oldest), .count(tx_cnt)
    );

    sport_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n),
        .push(eng_rx_push), .push_data(eng_rx_word & size_mask),
        .pop(rx_pop), .oldest(rx_oldest), .count(rx_cnt)
    );

    sport_engine #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_eng (
        .clk(clk), .rst_n(rst_n),
        .port_en(port_en), .loopback(loopback),
        .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .tx_word(tx_oldest),
        .xchg_ready(xchg_ready), .xchg_rx(xchg_rx),
        .xchg_valid(xchg_valid), .xchg_tx(xchg_tx),
        .tx_pop(eng_tx_pop), .rx_push(eng_rx_push), .rx_word(eng_rx_word),
        .busy(busy)
    );

    assign stat   = {busy, rx_cnt == FULL_CNT, rx_cnt != '0,
                     tx_cnt != FULL_CNT, tx_cnt == '0};
    assign raw    = {tx_cnt <= HALF_CNT, rx_cnt >= HALF_CNT, 2'b00};
    assign masked = raw & regs_q.imask;
    assign irq    = |masked;

    always_comb begin
        bus_rdata = '0;
        if (rd_acc) begin
            if (waddr >= A_IDBASE) begin
                bus_rdata = DATA_W'(id_byte(waddr[2:0]));
            end else begin
                case (waddr)
                    A_CTRL0:  bus_rdata = DATA_W'(regs_q.ctrl0);
                    A_CTRL1:  bus_rdata = DATA_W'(regs_q.ctrl1);
                    A_DATA:   bus_rdata = (rx_cnt != '0) ? rx_oldest : '0;
                    A_STAT:   bus_rdata = DATA_W'(stat);
                    A_PRESC:  bus_rdata = DATA_W'(regs_q.presc);
                    A_IMASK:  bus_rdata = DATA_W'(regs_q.imask);
                    A_RAW:    bus_rdata = DATA_W'(raw);
                    A_MASKED: bus_rdata = DATA_W'(masked);
                    default:  bus_rdata = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/sport_checks.sv
module sport_checks #(
    parameter int W     = 16,
    parameter int DEPTH = 8,
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] rx_cnt,
    input logic [CNT_W-1:0] tx_cnt,
    input logic             eng_rx_push,
    input logic             tx_push,
    input logic             port_en,
    input logic             busy,
    input logic             xchg_valid,
    input logic             xchg_ready,
    input logic [W-1:0]     xchg_tx,
    input logic             irq,
    input logic [3:0]       imask
);
    a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_cnt == CNT_W'(DEPTH)) |-> !eng_rx_push);

    a_r3_drop_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_cnt == CNT_W'(DEPTH)) |-> !tx_push);

    a_r8_request_held: assert property (@(posedge clk) disable iff (!rst_n)
        (xchg_valid && !xchg_ready) |=> (xchg_valid && $stable(xchg_tx)));

    a_r9_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!port_en && !xchg_valid) |=> !xchg_valid);

    a_r5_busy_while_pending: assert property (@(posedge clk) disable iff (!rst_n)
        xchg_valid |-> busy);

    a_r7_irq_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (imask != 4'd0));
endmodule

bind sport_regfifo sport_checks #(.W(DATA_W), .DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .rx_cnt(rx_cnt), .tx_cnt(tx_cnt),
    .eng_rx_push(eng_rx_push), .tx_push(tx_push), .port_en(port_en),
    .busy(busy), .xchg_valid(xchg_valid), .xchg_ready(xchg_ready),
    .xchg_tx(xchg_tx), .irq(irq), .imask(regs_q.imask)
);

// File: tb/tb_sport_regfifo.sv
`timescale 1ns/1ps
module tb_sport_regfifo;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0, wr = 1'b0;
    logic [11:0] addr = '0;
    logic [15:0] wdata = '0, rdata;
    logic        xv, xr = 1'b0;
    logic [15:0] xtx, xrx = '0;
    logic        irq;

    int checks = 0, errors = 0;
    logic resp_en = 1'b0;
    logic [15:0] seen [0:15];
    int nseen = 0;

    always #5 clk = ~clk;

    sport_regfifo dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata), .xchg_valid(xv), .xchg_ready(xr),
        .xchg_tx(xtx), .xchg_rx(xrx), .irq(irq)
    );

    // external responder: answers with (tx << 8) | (tx ^ 0x5A)
    initial begin
        forever begin
            @(negedge clk);
            xr  = resp_en && xv;
            xrx = {xtx[7:0], xtx[7:0] ^ 8'h5A};
            if (xr && nseen < 16) begin
                seen[nseen] = xtx;
                nseen++;
            end
        end
    end

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [15:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [15:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b0; addr = a;
        #1 d = rdata;
        @(posedge clk);
        @(negedge clk);
        sel = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [15:0] v;
        bus_read(12'h00C, v); check("R1 status", v, 16'h0003);
        bus_read(12'h018, v); check("R1 raw", v, 16'h0008);
        bus_read(12'h01C, v); check("R1 masked", v, 16'h0000);
        check("R1 irq", {15'd0, irq}, 16'h0000);
        bus_read(12'h008, v); check("R10 empty read", v, 16'h0000);
        bus_read(12'h00C, v); check("R10 status after empty read", v, 16'h0003);
    endtask

    task automatic t_id;
        logic [15:0] v;
        logic [7:0] exp [0:7] = '{8'h22, 8'h10, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
        for (int i = 0; i < 8; i++) begin
            bus_read(12'hFE0 + 12'(i * 4), v);
            check("R11 id byte", v, {8'h00, exp[i]});
        end
    endtask

    task automatic t_regs;
        logic [15:0] v;
        bus_write(12'h000, 16'h1234); bus_read(12'h000, v); check("R12 ctrl0", v, 16'h1234);
        bus_write(12'h004, 16'hFFF4); bus_read(12'h004, v); check("R12 ctrl1", v, 16'h0004);
        bus_write(12'h004, 16'h0000);
        bus_write(12'h010, 16'h01FF); bus_read(12'h010, v); check("R12 prescaler", v, 16'h00FF);
        bus_write(12'h014, 16'h00FF); bus_read(12'h014, v); check("R7 mask readback", v, 16'h000F);
        bus_write(12'h014, 16'h0008);
        bus_read(12'h01C, v); check("R7 masked tx", v, 16'h0008);
        check("R7 irq high", {15'd0, irq}, 16'h0001);
        bus_write(12'h014, 16'h0004);
        bus_read(12'h01C, v); check("R7 masked none", v, 16'h0000);
        check("R7 irq low", {15'd0, irq}, 16'h0000);
        bus_write(12'h014, 16'h0000);
    endtask

    task automatic t_full_drop;
        logic [15:0] v;
        bus_write(12'h004, 16'h0000);
        bus_write(12'h000, 16'h0007);
        for (int i = 0; i < 9; i++) bus_write(12'h008, 16'h01A0 + 16'(i));
        bus_read(12'h00C, v); check("R5 status tx full", v, 16'h0000);
        bus_read(12'h018, v); check("R6 raw tx over half", v, 16'h0000);
        idle(5);
        bus_read(12'h00C, v); check("R9 no move while off", v, 16'h0000);
        check("R9 no request", {15'd0, xv}, 16'h0000);
        bus_write(12'h004, 16'h0003);
        idle(12);
        bus_read(12'h00C, v); check("R5 status rx full", v, 16'h000F);
        bus_read(12'h018, v); check("R6 raw both", v, 16'h000C);
        for (int i = 0; i < 8; i++) begin
            bus_read(12'h008, v); check("R3 R2 R13 rx word", v, 16'h00A0 + 16'(i));
        end
        bus_read(12'h00C, v); check("R3 ninth dropped", v, 16'h0003);
        bus_read(12'h008, v); check("R10 read after drain", v, 16'h0000);
    endtask

    task automatic t_stall;
        logic [15:0] v;
        bus_write(12'h000, 16'h000F);
        bus_write(12'h004, 16'h0003);
        for (int i = 0; i < 12; i++) bus_write(12'h008, 16'h5000 + 16'(i));
        idle(6);
        bus_read(12'h00C, v); check("R4 status stalled", v, 16'h000E);
        bus_read(12'h018, v); check("R6 raw at watermarks", v, 16'h000C);
        bus_write(12'h014, 16'h0004);
        bus_read(12'h01C, v); check("R7 masked rx", v, 16'h0004);
        check("R7 irq rx", {15'd0, irq}, 16'h0001);
        bus_write(12'h014, 16'h0000);
        for (int i = 0; i < 12; i++) begin
            bus_read(12'h008, v); check("R4 order after stall", v, 16'h5000 + 16'(i));
        end
        idle(2);
        bus_read(12'h00C, v); check("R4 all drained", v, 16'h0003);
    endtask

    task automatic t_external;
        logic [15:0] v;
        logic [15:0] tx [0:2] = '{16'h0011, 16'h0022, 16'h0033};
        bus_write(12'h004, 16'h0000);
        bus_write(12'h000, 16'h0007);
        for (int i = 0; i < 3; i++) bus_write(12'h008, tx[i]);
        bus_write(12'h004, 16'h0002);
        idle(4);
        check("R8 request raised", {15'd0, xv}, 16'h0001);
        check("R8 oldest presented", xtx, 16'h0011);
        bus_read(12'h00C, v); check("R5 busy while waiting", v, 16'h0012);
        idle(4);
        check("R8 request held", xtx, 16'h0011);
        resp_en = 1'b1;
        idle(12);
        resp_en = 1'b0;
        check("R8 exchange count", 16'(nseen), 16'd3);
        for (int i = 0; i < 3; i++) check("R8 tx order", seen[i], tx[i]);
        for (int i = 0; i < 3; i++) begin
            bus_read(12'h008, v); check("R8 R2 rx stored masked", v, {8'h00, tx[i][7:0] ^ 8'h5A});
        end
        bus_read(12'h00C, v); check("R8 idle after", v, 16'h0003);
        check("R8 request dropped", {15'd0, xv}, 16'h0000);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_id;
        t_regs;
        t_full_drop;
        t_stall;
        t_external;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule